// File: doc/BRIEF.md
# Debug peripheral freeze controller

This block is a small register file on a simple 32-bit register bus. It holds a read-only device identification word, two low-power debug bits that ask the clock controller to keep the core clocks running in stop and standby modes, and two banks of per-peripheral freeze bits. While the CPU reports that it is halted, every peripheral whose freeze bit is set loses its counter clock enable, so timers, watchdogs, the real-time clock, the CAN controller and the SMBus timeout stand still while a debugger inspects the system.

The configuration state lives in the power-on reset domain only. The system reset input does not clear it, and the bus keeps accepting writes while the system reset is held, so a debugger can arm the freeze and low-power bits before software starts. The counter enables are registered, so they change one clock edge after the halt input or the freeze register changes and never glitch.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: A word read at offset 0x00 returns {REV_ID[15:0], 4'b0110, DEV_ID[11:0]} (revision in bits 31:16, constant 0110 in bits 15:12, device in bits 11:0); writes to offset 0x00 change nothing.
- R2: Offset 0x04 holds two low-power bits: bit 1 drives keepStopClk and bit 2 drives keepStandbyClk directly; all other bits of this word read 0 and ignore writes.
- R3: Offset 0x08 is freeze bank 0 with implemented bits given by LO_MASK (default bits 0,1,4,5,8,10,11,12,21,25) and offset 0x0C is freeze bank 1 with implemented bits given by HI_MASK (default bits 11,16,17,18); unimplemented bits read 0 and ignore writes.
- R4: Bit n of cntEnLo (cntEnHi) is 0 exactly when bit n of bank 0 (bank 1) and cpuHalted were both 1 at the previous rising clock edge, and 1 otherwise; unimplemented positions are therefore always 1.
- R5: Asserting porRstN (active low, asynchronous) clears both low-power bits and both freeze banks and sets every counter enable to 1.
- R6: The system reset input sysRstN has no effect on any register, and word writes issued while sysRstN is low take effect as usual.
- R7: An access with busSize other than 2'b10 (word) or with busAddr[1:0] not 00 writes nothing and reads 0.
- R8: busRdata is combinational in the cycle of a valid word read; it is 0 when no read is selected and for offsets 0x10 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low; leaves this block untouched |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size; 2'b10 is a 32-bit word |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| cpuHalted | input | 1 | CPU is halted by the debugger |
| keepStopClk | output | 1 | Keep core clocks in stop mode |
| keepStandbyClk | output | 1 | Keep core clocks in standby mode |
| cntEnLo | output | 32 | Counter clock enables for bank 0 peripherals |
| cntEnHi | output | 32 | Counter clock enables for bank 1 peripherals |

## Verification
Read data is due in the same cycle as the read request, so the bench samples busRdata one time step after it drives the request, before the edge. Register contents and the low-power outputs change on the edge that accepts a write, while each counter enable reflects the halt input and freeze bits of the edge before, so it moves one edge after either of them. The bench updates its reference model at each rising edge from the inputs it held and compares every output at the following falling edge, which keeps each comparison in the cycle where the result is due.

// File: rtl/dbg_frz_pkg.sv
package dbg_frz_pkg;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_ID   = 3'd1,
    RD_LP   = 3'd2,
    RD_LO   = 3'd3,
    RD_HI   = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic   wrLp;
    logic   wrLo;
    logic   wrHi;
    rdSrc_e rdSrc;
  } busStrobe_t;

  localparam logic [1:0] SIZE_WORD = 2'b10;
  localparam int         NUM_BANKS = 2;
  localparam logic [3:0] ID_FILL   = 4'b0110;

endpackage

// File: rtl/frz_bus_ctrl.sv
module frz_bus_ctrl
  import dbg_frz_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic             wordAcc;
  logic [IDX_W-1:0] regIdx;

  always_comb begin
    wordAcc = busSel && (busSize == SIZE_WORD) && (busAddr[1:0] == 2'b00);
    regIdx  = busAddr[ADDR_W-1:2];
    strobe  = '0;
    if (wordAcc) begin
      if (busWrite) begin
        strobe.wrLp = (regIdx == IDX_W'(1));
        strobe.wrLo = (regIdx == IDX_W'(2));
        strobe.wrHi = (regIdx == IDX_W'(3));
      end else begin
        case (regIdx)
          IDX_W'(0): strobe.rdSrc = RD_ID;
          IDX_W'(1): strobe.rdSrc = RD_LP;
          IDX_W'(2): strobe.rdSrc = RD_LO;
          IDX_W'(3): strobe.rdSrc = RD_HI;
          default:   strobe.rdSrc = RD_NONE;
        endcase
      end
    end
  end

  // R7
  narrow_access_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (busSel && busSize != SIZE_WORD) |-> (strobe == '0));

  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strobe.wrLp, strobe.wrLo, strobe.wrHi}));

endmodule

// File: rtl/frz_regs_dp.sv
module frz_regs_dp
  import dbg_frz_pkg::*;
#(
  parameter logic [31:0] LO_MASK = 32'h0220_1D33,
  parameter logic [31:0] HI_MASK = 32'h0007_0800,
  parameter logic [15:0] REV_ID  = 16'h1000,
  parameter logic [11:0] DEV_ID  = 12'h440
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        cpuHalted,
  input  busStrobe_t  strobe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        keepStopClk,
  output logic        keepStandbyClk,
  output logic [31:0] cntEnLo,
  output logic [31:0] cntEnHi
);

  localparam int          STOP_POS    = 1;
  localparam int          STANDBY_POS = 2;
  localparam logic [31:0] ID_WORD     = {REV_ID, ID_FILL, DEV_ID};

  logic        lpStop;
  logic        lpStandby;
  logic [31:0] fzBank [NUM_BANKS];
  logic [31:0] enBank [NUM_BANKS];
  logic [31:0] fzLo;
  logic [31:0] fzHi;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      lpStop    <= 1'b0;
      lpStandby <= 1'b0;
    end else if (strobe.wrLp) begin
      lpStop    <= busWdata[STOP_POS];
      lpStandby <= busWdata[STANDBY_POS];
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    localparam logic [31:0] BANK_MASK = (g == 0) ? LO_MASK : HI_MASK;
    logic bankWr;
    assign bankWr = (g == 0) ? strobe.wrLo : strobe.wrHi;

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        fzBank[g] <= '0;
      end else if (bankWr) begin
        fzBank[g] <= busWdata & BANK_MASK;
      end
    end

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        enBank[g] <= '1;
      end else begin
        enBank[g] <= ~(fzBank[g] & {32{cpuHalted}});
      end
    end
  end

  assign fzLo           = fzBank[0];
  assign fzHi           = fzBank[1];
  assign cntEnLo        = enBank[0];
  assign cntEnHi        = enBank[1];
  assign keepStopClk    = lpStop;
  assign keepStandbyClk = lpStandby;

  always_comb begin
    busRdata = '0;
    case (strobe.rdSrc)
      RD_ID: busRdata = ID_WORD;
      RD_LP: begin
        busRdata[STOP_POS]    = lpStop;
        busRdata[STANDBY_POS] = lpStandby;
      end
      RD_LO:   busRdata = fzLo;
      RD_HI:   busRdata = fzHi;
      default: busRdata = '0;
    endcase
  end

  // R4
  run_when_free_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !$past(cpuHalted) |-> ((&cntEnLo) && (&cntEnHi)));

  // R4
  frozen_when_halted_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $past(cpuHalted) |-> (((cntEnLo & $past(fzLo)) == '0) && ((cntEnHi & $past(fzHi)) == '0)));

  // R6
  sys_reset_write_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!sysRstN && strobe.wrLo) |=> (fzLo == ($past(busWdata) & LO_MASK)));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !strobe.wrHi |=> $stable(fzHi));

endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import dbg_frz_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter logic [31:0] LO_MASK = 32'h0220_1D33,
  parameter logic [31:0] HI_MASK = 32'h0007_0800,
  parameter logic [15:0] REV_ID  = 16'h1000,
  parameter logic [11:0] DEV_ID  = 12'h440
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              cpuHalted,
  output logic              keepStopClk,
  output logic              keepStandbyClk,
  output logic [31:0]       cntEnLo,
  output logic [31:0]       cntEnHi
);

  busStrobe_t strobe;

  frz_bus_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  frz_regs_dp #(
    .LO_MASK (LO_MASK),
    .HI_MASK (HI_MASK),
    .REV_ID  (REV_ID),
    .DEV_ID  (DEV_ID)
  ) uData (
    .clk            (clk),
    .porRstN        (porRstN),
    .sysRstN        (sysRstN),
    .cpuHalted      (cpuHalted),
    .strobe         (strobe),
    .busWdata       (busWdata),
    .busRdata       (busRdata),
    .keepStopClk    (keepStopClk),
    .keepStandbyClk (keepStandbyClk),
    .cntEnLo        (cntEnLo),
    .cntEnHi        (cntEnHi)
  );

endmodule

// File: tb/dbg_freeze_ctrl_test.sv
module dbg_freeze_ctrl_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 6;
  localparam logic [31:0] LOM        = 32'h0220_1D33;
  localparam logic [31:0] HIM        = 32'h0007_0800;
  localparam logic [31:0] IDV        = {16'h1000, 4'b0110, 12'h440};

  logic          clk = 1'b0;
  logic          porRstN = 1'b0;
  logic          sysRstN = 1'b1;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [1:0]    busSize = 2'b10;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          cpuHalted = 1'b0;
  logic          keepStopClk;
  logic          keepStandbyClk;
  logic [31:0]   cntEnLo;
  logic [31:0]   cntEnHi;

  dbg_freeze_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .busSel(busSel), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cpuHalted(cpuHalted), .keepStopClk(keepStopClk),
    .keepStandbyClk(keepStandbyClk), .cntEnLo(cntEnLo), .cntEnHi(cntEnHi)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [1:0]  mLp = '0;   // [0] stop keep, [1] standby keep
  logic [31:0] mLo = '0;
  logic [31:0] mHi = '0;
  logic [31:0] mEnLo = '1;
  logic [31:0] mEnHi = '1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit wordOk(logic s, logic [1:0] sz, logic [AW-1:0] a);
    return s && (sz == 2'b10) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] expRd(logic s, logic [1:0] sz, logic [AW-1:0] a);
    int idx;
    if (!wordOk(s, sz, a)) return '0;
    idx = int'(a) / 4;
    case (idx)
      0: return IDV;
      1: return {29'b0, mLp[1], mLp[0], 1'b0};
      2: return mLo;
      3: return mHi;
      default: return '0;
    endcase
  endfunction

  task automatic cyc(string tag, logic s, logic w, logic [1:0] sz,
                     logic [AW-1:0] a, logic [31:0] wd, logic h);
    logic [31:0] nLo;
    logic [31:0] nHi;
    busSel = s; busWrite = w; busSize = sz; busAddr = a; busWdata = wd;
    cpuHalted = h;
    #1;
    if (s && !w) chk(tag, busRdata, expRd(s, sz, a));
    else         chk("R8 idle rdata", busRdata, '0);
    @(posedge clk);
    nLo = ~(mLo & {32{h}});
    nHi = ~(mHi & {32{h}});
    if (w && wordOk(s, sz, a)) begin
      case (int'(a) / 4)
        1: mLp = {wd[2], wd[1]};
        2: mLo = wd & LOM;
        3: mHi = wd & HIM;
        default: ;
      endcase
    end
    mEnLo = nLo;
    mEnHi = nHi;
    @(negedge clk);
    chk("R4 bank0 enables", cntEnLo, mEnLo);
    chk("R4 bank1 enables", cntEnHi, mEnHi);
    chk("R2 keep outputs", {30'b0, keepStandbyClk, keepStopClk}, {30'b0, mLp[1], mLp[0]});
  endtask

  task automatic idle(int n, logic h);
    for (int i = 0; i < n; i++) cyc("R8", 1'b0, 1'b0, 2'b10, '0, '0, h);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic h);
    cyc(tag, 1'b1, 1'b0, 2'b10, a, '0, h);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic h);
    cyc("R8", 1'b1, 1'b1, 2'b10, a, d, h);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    // R5 reset state
    chk("R5 reset bank0 enables", cntEnLo, '1);
    chk("R5 reset bank1 enables", cntEnHi, '1);
    chk("R5 reset keep outputs", {30'b0, keepStandbyClk, keepStopClk}, '0);
    @(negedge clk);
    porRstN = 1'b1;

    // R1 id word, R5 cleared registers
    rd("R1 id read", 6'h00, 1'b0);
    rd("R5 lp after reset", 6'h04, 1'b0);
    rd("R5 bank0 after reset", 6'h08, 1'b0);
    rd("R5 bank1 after reset", 6'h0C, 1'b0);
    wr(6'h00, 32'h0000_0000, 1'b0);
    rd("R1 id after write", 6'h00, 1'b0);

    // R2 R3 write all ones, reserved bits drop
    wr(6'h04, 32'hFFFF_FFFF, 1'b0);
    rd("R2 lp readback", 6'h04, 1'b0);
    wr(6'h08, 32'hFFFF_FFFF, 1'b0);
    rd("R3 bank0 readback", 6'h08, 1'b0);
    wr(6'h0C, 32'hFFFF_FFFF, 1'b0);
    rd("R3 bank1 readback", 6'h0C, 1'b0);
    wr(6'h04, 32'h0000_0002, 1'b0);
    rd("R2 stop only", 6'h04, 1'b0);

    // R4 halt patterns
    idle(3, 1'b1);
    idle(1, 1'b0);
    idle(2, 1'b1);
    wr(6'h08, 32'h0000_0011, 1'b1);
    idle(2, 1'b1);
    wr(6'h0C, 32'h0000_0000, 1'b1);
    idle(2, 1'b0);

    // R7 narrow and misaligned accesses
    cyc("R7", 1'b1, 1'b1, 2'b00, 6'h08, 32'hFFFF_FFFF, 1'b0);
    cyc("R7", 1'b1, 1'b1, 2'b01, 6'h0C, 32'hFFFF_FFFF, 1'b0);
    cyc("R7", 1'b1, 1'b1, 2'b10, 6'h09, 32'h0000_0000, 1'b0);
    cyc("R7 narrow read zero", 1'b1, 1'b0, 2'b01, 6'h08, '0, 1'b0);
    cyc("R7 byte read zero", 1'b1, 1'b0, 2'b00, 6'h00, '0, 1'b0);
    cyc("R7 misaligned read zero", 1'b1, 1'b0, 2'b10, 6'h0A, '0, 1'b0);
    rd("R7 bank0 unchanged", 6'h08, 1'b0);
    rd("R7 bank1 unchanged", 6'h0C, 1'b0);

    // R8 unmapped
    rd("R8 unmapped 0x10", 6'h10, 1'b0);
    rd("R8 unmapped 0x3C", 6'h3C, 1'b0);

    // R6 system reset
    sysRstN = 1'b0;
    idle(3, 1'b1);
    rd("R6 bank0 kept in sys reset", 6'h08, 1'b1);
    rd("R6 lp kept in sys reset", 6'h04, 1'b1);
    wr(6'h0C, 32'h0004_0800, 1'b1);
    wr(6'h04, 32'h0000_0004, 1'b1);
    rd("R6 bank1 written in sys reset", 6'h0C, 1'b1);
    rd("R6 lp written in sys reset", 6'h04, 1'b1);
    sysRstN = 1'b1;
    idle(2, 1'b1);
    rd("R6 bank1 after sys reset", 6'h0C, 1'b0);

    // R4 pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:1])
        3'd0: wr(6'h08, {lfsr, ~lfsr}, lfsr[0]);
        3'd1: wr(6'h0C, {~lfsr, lfsr}, lfsr[0]);
        3'd2: rd("R3 random bank0", 6'h08, lfsr[0]);
        3'd3: rd("R3 random bank1", 6'h0C, lfsr[0]);
        3'd4: wr(6'h04, {16'h0, lfsr}, lfsr[0]);
        default: idle(1, lfsr[0] | lfsr[5]);
      endcase
    end

    // R5 power-on reset mid run
    wr(6'h08, 32'hFFFF_FFFF, 1'b1);
    wr(6'h04, 32'h0000_0006, 1'b1);
    idle(1, 1'b1);
    porRstN = 1'b0;
    #1;
    chk("R5 por bank0 enables", cntEnLo, '1);
    chk("R5 por bank1 enables", cntEnHi, '1);
    chk("R5 por keep outputs", {30'b0, keepStandbyClk, keepStopClk}, '0);
    mLp = '0; mLo = '0; mHi = '0; mEnLo = '1; mEnHi = '1;
    @(negedge clk);
    porRstN = 1'b1;
    rd("R5 bank0 after por", 6'h08, 1'b1);
    rd("R5 lp after por", 6'h04, 1'b1);
    idle(2, 1'b1);

    finishRun();
  end

endmodule